// File: doc/BRIEF.md
# Truncating Double-to-Quadword Integer Converter

This unit takes one IEEE-754 binary64 operand and returns the signed 64-bit two's-complement integer nearest to zero, i.e. the fractional part is simply dropped. No rounding-mode input exists; the direction is always toward zero. Next to the integer it reports two status bits: an invalid bit for operands whose truncated value has no signed 64-bit representation, and an inexact bit for operands whose truncation discarded a nonzero fraction.

The operand is presented with a valid strobe and the result appears one clock later from a single register stage. Operands that cannot be represented (NaNs of either kind, both infinities, and magnitudes of 2^63 or beyond apart from exactly -2^63) yield the fixed integer-indefinite pattern with only the high bit set, rather than a saturated value. Exception delivery, lane masking and any register file belong to the surrounding datapath.

Top module: `f2i_trunc_conv`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and the result and flags for that operand are visible; when `in_valid` is low at an edge, `out_valid` is low after it.
- R2: For an operand whose magnitude is at least 1 and whose truncated value fits in a signed 64-bit integer, `out_int` is that value rounded toward zero (e.g. 2.75 gives 2, -2.75 gives -2).
- R3: `out_inexact` is 1 exactly when a finite, representable operand loses a nonzero fractional part; integral operands give 0.
- R4: Operands with magnitude below 1, subnormals included, give `out_int` = 0 and `out_invalid` = 0; `out_inexact` is 1 unless the operand is +0 or -0 (bits 62..0 all zero), where it is 0.
- R5: An operand with all exponent bits (62..52) set, that is any NaN (quiet or signaling) or either infinity, gives `out_int` = 0x8000_0000_0000_0000, `out_invalid` = 1, `out_inexact` = 0.
- R6: A finite operand whose truncated magnitude is 2^63 or more gives `out_int` = 0x8000_0000_0000_0000 and `out_invalid` = 1, except the operand 0xC3E0_0000_0000_0000 (exactly -2^63), which gives that same integer with `out_invalid` = 0 and `out_inexact` = 0.
- R7: Negative in-range operands give the two's-complement negation of the truncated magnitude, and non-negative operands never give a result with bit 63 set unless invalid.
- R8: `out_invalid` and `out_inexact` are never 1 together.
- R9: While `rst_n` is low, `out_valid`, `out_int`, `out_invalid` and `out_inexact` are all 0.
- R10: When `in_valid` is low at an edge, `out_int`, `out_invalid` and `out_inexact` keep their previous values regardless of `in_op`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand: bit 63 sign, bits 62..52 biased exponent, bits 51..0 fraction |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 64 | Signed truncated integer or indefinite pattern |
| out_invalid | output | 1 | Operand not representable as signed 64-bit |
| out_inexact | output | 1 | Nonzero fraction discarded |

## Verification
The hardest region to reach from the ports is the narrow band around 2^63: the one negative operand that is exactly representable, its immediate neighbours that are not, and the largest positive operand just below the limit, which uniformly drawn bit patterns almost never hit. The same holds for exponents near 52, where only the lowest fraction bit decides inexactness. Directed operands cover these edges and both zero signs, and a long pseudo-random run forces the exponent field into the window from 1000 to 1099 most of the time so that every shift distance and both overflow sides are visited, each cycle compared against a behavioural reference.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int EXP_W  = 11;
  localparam int MAN_W  = 52;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int INT_W  = 64;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SH_W   = $clog2(INT_W);

  // Biased exponent at which the magnitude reaches 2^(INT_W-1)
  localparam logic [EXP_W-1:0] EXP_BIAS_E = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_LIMIT_E = EXP_W'(BIAS + INT_W - 1);

  // Pattern returned for every unrepresentable operand
  localparam logic [INT_W-1:0] INT_INDEF = {1'b1, {(INT_W-1){1'b0}}};

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_t;

  typedef enum logic [2:0] {
    CLS_ZERO,     // +0 / -0
    CLS_TINY,     // 0 < |x| < 1, subnormals included
    CLS_INRANGE,  // 1 <= |x| < 2^(INT_W-1)
    CLS_EDGE_MIN, // exactly -2^(INT_W-1)
    CLS_OVER,     // finite, too large
    CLS_SPECIAL   // NaN or infinity
  } cls_t;

  function automatic logic [INT_W-1:0] twos_neg(input logic [INT_W-1:0] v);
    return (~v) + {{(INT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [INT_W-1:0] apply_sign(input logic neg,
                                                  input logic [INT_W-1:0] mag);
    return neg ? twos_neg(mag) : mag;
  endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
(
  input  fp_t             op,
  output cls_t            cls,
  output logic [SH_W-1:0] shamt
);

  logic exp_ones;
  logic exp_zero;
  logic man_zero;
  logic below_one;
  logic at_or_over;
  logic edge_min;

  always_comb begin
    exp_ones   = &op.exp;
    exp_zero   = (op.exp == '0);
    man_zero   = (op.man == '0);
    below_one  = (op.exp < EXP_BIAS_E);
    at_or_over = (op.exp >= EXP_LIMIT_E);
    edge_min   = op.sgn && (op.exp == EXP_LIMIT_E) && man_zero;
  end

  always_comb begin
    if (exp_ones)                 cls = CLS_SPECIAL;
    else if (exp_zero && man_zero) cls = CLS_ZERO;
    else if (below_one)           cls = CLS_TINY;
    else if (edge_min)            cls = CLS_EDGE_MIN;
    else if (at_or_over)          cls = CLS_OVER;
    else                          cls = CLS_INRANGE;
  end

  // Unbiased exponent; only meaningful (0..INT_W-2) for CLS_INRANGE
  always_comb begin
    if (cls == CLS_INRANGE) shamt = SH_W'(op.exp - EXP_BIAS_E);
    else                    shamt = '0;
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  logic [MAN_W-1:0] man,
  input  logic [SH_W-1:0]  shamt,
  output logic [INT_W-1:0] mag,
  output logic             frac_nz
);

  // Fixed-point window: INT_W integer bits above MAN_W fraction bits
  localparam int WIDE_W = INT_W + MAN_W;

  logic [MAN_W:0]    sig;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    sig     = {1'b1, man};
    wide    = WIDE_W'(sig) << shamt;
    mag     = wide[WIDE_W-1:MAN_W];
    frac_nz = |wide[MAN_W-1:0];
  end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
(
  input  cls_t             cls,
  input  logic             sgn,
  input  logic [INT_W-1:0] mag,
  input  logic             frac_nz,
  output logic [INT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);

  always_comb begin
    result  = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    case (cls)
      CLS_ZERO: begin
        result = '0;
      end
      CLS_TINY: begin
        result  = '0;
        inexact = 1'b1;
      end
      CLS_INRANGE: begin
        result  = apply_sign(sgn, mag);
        inexact = frac_nz;
      end
      CLS_EDGE_MIN: begin
        result = INT_INDEF;
      end
      default: begin
        result  = INT_INDEF;
        invalid = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_op,
  output logic             out_valid,
  output logic [INT_W-1:0] out_int,
  output logic             out_invalid,
  output logic             out_inexact
);

  fp_t             op_s;
  cls_t            cls_w;
  logic [SH_W-1:0] shamt_w;
  logic [INT_W-1:0] mag_w;
  logic            frac_nz_w;
  logic [INT_W-1:0] res_w;
  logic            inv_w;
  logic            inx_w;

  // Named events for the checker
  logic            is_special;
  logic            is_tiny;

  assign op_s       = fp_t'(in_op);
  assign is_special = (cls_w == CLS_SPECIAL);
  assign is_tiny    = (cls_w == CLS_TINY) || (cls_w == CLS_ZERO);

  f2i_classify u_cls (
    .op    (op_s),
    .cls   (cls_w),
    .shamt (shamt_w)
  );

  f2i_align u_aln (
    .man     (op_s.man),
    .shamt   (shamt_w),
    .mag     (mag_w),
    .frac_nz (frac_nz_w)
  );

  f2i_pack u_pck (
    .cls     (cls_w),
    .sgn     (op_s.sgn),
    .mag     (mag_w),
    .frac_nz (frac_nz_w),
    .result  (res_w),
    .invalid (inv_w),
    .inexact (inx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res_w;
        out_invalid <= inv_w;
        out_inexact <= inx_w;
      end
    end
  end

endmodule

// File: rtl/f2i_trunc_conv_chk.sv
module f2i_trunc_conv_chk
  import f2i_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [FP_W-1:0]  in_op,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             cls_special,
  input logic             cls_tiny
);

  localparam logic [FP_W-1:0] NEG_LIMIT_FP = {1'b1, EXP_LIMIT_E, {MAN_W{1'b0}}};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_int) && $stable(out_invalid) && $stable(out_inexact)));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  a_r5_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_special) |=> (out_invalid && !out_inexact && out_int == INT_INDEF));

  a_r5_invalid_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_int == INT_INDEF));

  a_r4_tiny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_tiny) |=> (out_int == '0 && !out_invalid));

  a_r4_signed_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[FP_W-2:0] == '0) |=> (out_int == '0 && !out_inexact && !out_invalid));

  a_r6_neg_limit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == NEG_LIMIT_FP) |=> (!out_invalid && !out_inexact && out_int == INT_INDEF));

  a_r7_positive_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op[FP_W-1]) |=> (out_invalid || !out_int[INT_W-1]));

endmodule

bind f2i_trunc_conv f2i_trunc_conv_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .cls_special (is_special),
  .cls_tiny    (is_tiny)
);

// File: tb/f2i_trunc_conv_test.sv
module f2i_trunc_conv_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_op;
  logic        out_valid;
  logic [63:0] out_int;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state: what the outputs should show after the next edge
  logic        m_valid = 1'b0;
  logic [63:0] m_int   = '0;
  logic        m_inv   = 1'b0;
  logic        m_inx   = 1'b0;

  always #5 clk = ~clk;

  f2i_trunc_conv uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
  );

  // Behavioural reference: integer exponent arithmetic and bit masks
  function automatic void ref_conv(input logic [63:0] x, output logic [63:0] r,
                                   output logic inv, output logic inx);
    int          e;
    logic [52:0] s;
    logic [63:0] m;
    e   = int'(x[62:52]) - 1023;
    s   = {1'b1, x[51:0]};
    r   = 64'h0;
    inv = 1'b0;
    inx = 1'b0;
    if (x[62:52] == 11'h7FF) begin
      r = 64'h8000_0000_0000_0000; inv = 1'b1;
    end else if (e < 0) begin
      inx = (x[62:0] != 63'h0);
    end else if (e >= 63) begin
      r = 64'h8000_0000_0000_0000;
      inv = (x != 64'hC3E0_0000_0000_0000);
    end else begin
      if (e >= 52) begin
        m = 64'(s) << (e - 52);
      end else begin
        m   = 64'(s) >> (52 - e);
        inx = ((s & ((53'd1 << (52 - e)) - 53'd1)) != 53'd0);
      end
      r = x[63] ? (64'h0 - m) : m;
    end
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== m_valid || out_int !== m_int ||
        out_invalid !== m_inv || out_inexact !== m_inx) begin
      errors++;
      $display("FAIL %s: got v=%0b int=%h inv=%0b inx=%0b, expected v=%0b int=%h inv=%0b inx=%0b",
               tag, out_valid, out_int, out_invalid, out_inexact,
               m_valid, m_int, m_inv, m_inx);
    end
  endtask

  // Called right after a falling edge; returns right after the next one
  task automatic drive(input logic v, input logic [63:0] op, input string tag);
    in_valid = v;
    in_op    = op;
    m_valid  = v;
    if (v) ref_conv(op, m_int, m_inv, m_inx);
    @(posedge clk);
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog expired, got no completion, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_op    = 64'h4006_0000_0000_0000;
    repeat (3) @(negedge clk);
    compare("R9 reset state");
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);

    // R2 / R3 / R7 in-range truncation
    drive(1'b1, 64'h4006_0000_0000_0000, "R2 2.75");
    drive(1'b1, 64'hC006_0000_0000_0000, "R7 -2.75");
    drive(1'b1, 64'h3FF0_0000_0000_0000, "R3 1.0 exact");
    drive(1'b1, 64'h4330_0000_0000_0000, "R3 2^52 exact");
    drive(1'b1, 64'h432F_FFFF_FFFF_FFFF, "R3 2^52-0.5");
    drive(1'b1, 64'hC32F_FFFF_FFFF_FFFF, "R7 -(2^52-0.5)");
    drive(1'b1, 64'h43DF_FFFF_FFFF_FFFF, "R2 largest below 2^63");
    drive(1'b1, 64'hC3DF_FFFF_FFFF_FFFF, "R7 most negative below limit");

    // R10 hold with garbage on the operand bus
    drive(1'b0, 64'h7FF8_0000_0000_0000, "R10 hold after idle");
    drive(1'b0, 64'h0000_0000_0000_0000, "R10 hold second idle");

    // R4 small magnitudes
    drive(1'b1, 64'h0000_0000_0000_0000, "R4 +0");
    drive(1'b1, 64'h8000_0000_0000_0000, "R4 -0");
    drive(1'b1, 64'h3FE0_0000_0000_0000, "R4 0.5");
    drive(1'b1, 64'hBFEF_FFFF_FFFF_FFFF, "R4 -0.999");
    drive(1'b1, 64'h0000_0000_0000_0001, "R4 smallest subnormal");
    drive(1'b1, 64'h800F_FFFF_FFFF_FFFF, "R4 negative subnormal");

    // R5 specials
    drive(1'b1, 64'h7FF0_0000_0000_0000, "R5 +inf");
    drive(1'b1, 64'hFFF0_0000_0000_0000, "R5 -inf");
    drive(1'b1, 64'h7FF8_0000_0000_0000, "R5 quiet NaN");
    drive(1'b1, 64'h7FF0_0000_0000_0001, "R5 signaling NaN");
    drive(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 negative NaN");

    // R6 / R8 overflow boundary
    drive(1'b1, 64'h43E0_0000_0000_0000, "R6 +2^63");
    drive(1'b1, 64'hC3E0_0000_0000_0000, "R6 exact -2^63");
    drive(1'b1, 64'hC3E0_0000_0000_0001, "R6 just beyond -2^63");
    drive(1'b1, 64'h7E37_E43C_8800_759C, "R8 huge positive");
    drive(1'b0, 64'h4006_0000_0000_0000, "R1 idle drop of valid");

    // Pseudo-random sweep, exponent steered into the interesting window
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] x;
      x = {$urandom, $urandom};
      if (($urandom % 8) != 0) x[62:52] = 11'(1000 + ($urandom % 100));
      drive((($urandom % 4) != 0), x, "R3 random sweep");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule